// File: doc/BRIEF.md
# Type 1 Configuration Port Decoder

This block sits behind the I/O decode of a host bridge and turns CPU port accesses into configuration-space requests. Software first writes a full 32-bit word to the address port. That word chooses a bus, a device/function, a dword register and an enable bit. Software then reads or writes the four-byte data window. Each window access that is enabled becomes one request on a back-end port toward a configuration target. The request carries the bus, the devfn, a 10-bit dword index (which covers 4096 bytes per function), the byte enables and the write data.

The CPU side is a simple I/O bus. It has a 16-bit byte port address and byte enables that are relative to the addressed dword. The strobes are held until `io_ready` is seen high at a rising clock edge. Accesses to the address register, to a disabled window, or to foreign ports complete in the same cycle. Enabled window accesses stall the CPU until the back end answers, or until a fixed timeout expires.

Top module: `cfg_port_decoder`

## Requirements
- R1: A write to port 0x0CF8 with `io_be`=4'b1111 loads the address register. A later dword read of 0x0CF8 returns the written value with bits 30:28 and 1:0 forced to zero.
- R2: A write that hits the address dword with any byte-enable pattern other than 4'b1111 leaves the address register unchanged. This includes a single-byte write to 0x0CFB with `io_be`=4'b1000.
- R3: A window request carries these address-register fields: `req_bus` from bits 23:16 and `req_devfn` from bits 15:8. `req_dw_idx` carries bits 27:24 in its upper four bits and bits 7:2 in its lower six bits.
- R4: When address bit 31 is set, an access to ports 0x0CFC–0x0CFF issues one request with `req_be` equal to `io_be`. Byte lane n (`io_be` bit n) is data bits 8n+7:8n. A byte at 0x0CFC+n uses bit n, and a word at 0x0CFC or 0x0CFE uses 4'b0011 or 4'b1100. Writes carry `io_wdata` and reads return `rsp_rdata`.
- R5: When address bit 31 is clear, a window access issues no request and completes in the cycle it is presented. A read then returns 32'hFFFF_FFFF.
- R6: An enabled window access holds `io_ready` low while `req_valid` is high. The request fields stay stable until `rsp_ack`. `io_ready` rises in the cycle after the acknowledging edge, so an access whose ack comes d cycles after `req_valid` rises sees ready d+2 cycles after it was presented.
- R7: If `rsp_ack` does not arrive within TIMEOUT_CYCLES cycles of `req_valid`, the request is dropped. The access completes, and a read returns 32'hFFFF_FFFF.
- R8: Any other port, and any access whose lowest enabled lane differs from `io_port[1:0]`, completes in one cycle. It issues no request, leaves the address register unchanged, and reads as 32'hFFFF_FFFF.
- R9: After reset the address register reads zero, `req_valid` is low, and `io_ready` is low while no strobe is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_port | input | 16 | CPU I/O byte port address |
| io_be | input | 4 | Byte lanes within the addressed dword |
| io_rd | input | 1 | Read strobe, held until ready |
| io_wr | input | 1 | Write strobe, held until ready |
| io_wdata | input | 32 | Write data on its byte lanes |
| io_rdata | output | 32 | Read data, valid with io_ready |
| io_ready | output | 1 | Access completes at this clock edge |
| req_valid | output | 1 | Configuration request outstanding |
| req_write | output | 1 | Request is a write |
| req_bus | output | 8 | Target bus number |
| req_devfn | output | 8 | Target device/function |
| req_dw_idx | output | 10 | Dword register index within the function |
| req_be | output | 4 | Byte enables of the request |
| req_wdata | output | 32 | Request write data |
| rsp_ack | input | 1 | Back end has completed the request |
| rsp_rdata | input | 32 | Back-end read data, valid with rsp_ack |

## Verification
The hardest path to reach from the ports is the silent target. Driving it needs an enabled window access whose back end never acknowledges, so that the timeout counter alone ends the stall. The bench's target model has a per-access response delay, one value of which means no answer at all. With it the bench sweeps acknowledge delays and then withholds the ack for a read and a write. The malformed-lane and partial-address-write cases are reached by presenting every non-full byte-enable pattern against the address dword, with the port offset set to agree with or contradict the lowest enabled lane.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

    localparam int DATA_W  = 32;
    localparam int LANES   = DATA_W / 8;
    localparam int IDX_W   = 10;

    // bits kept in the address register: enable, extended offset, bus, devfn, dword
    localparam logic [DATA_W-1:0] ADDR_KEEP_MASK = 32'h8FFF_FFFC;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_ADDR,
        ACC_WIN,
        ACC_OTHER
    } acc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BUSY,
        ST_DONE
    } xact_state_e;

    typedef struct packed {
        logic [7:0]       bus;
        logic [7:0]       devfn;
        logic [IDX_W-1:0] dw_idx;
    } cfg_target_t;

    function automatic logic [1:0] first_lane(input logic [LANES-1:0] be);
        logic [1:0] r;
        r = 2'd0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (be[i]) r = 2'(i);
        end
        return r;
    endfunction

    function automatic cfg_target_t target_of(input logic [DATA_W-1:0] a);
        cfg_target_t t;
        t.bus    = a[23:16];
        t.devfn  = a[15:8];
        t.dw_idx = {a[27:24], a[7:2]};
        return t;
    endfunction

endpackage

// File: rtl/cfg_port_decode.sv
module cfg_port_decode
    import cfg_port_pkg::*;
#(
    parameter logic [15:0] ADDR_PORT = 16'h0CF8,
    parameter logic [15:0] DATA_PORT = 16'h0CFC
) (
    input  logic [15:0]      io_port,
    input  logic [LANES-1:0] io_be,
    input  logic             io_rd,
    input  logic             io_wr,
    output acc_kind_e        kind
);

    logic strobe;
    logic lanes_ok;

    always_comb begin
        strobe   = io_rd | io_wr;
        lanes_ok = (io_be != '0) && (first_lane(io_be) == io_port[1:0]);
        if (!strobe) begin
            kind = ACC_NONE;
        end else if (!lanes_ok) begin
            kind = ACC_OTHER;
        end else if (io_port[15:2] == ADDR_PORT[15:2]) begin
            kind = ACC_ADDR;
        end else if (io_port[15:2] == DATA_PORT[15:2]) begin
            kind = ACC_WIN;
        end else begin
            kind = ACC_OTHER;
        end
    end

endmodule

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg
    import cfg_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  logic [LANES-1:0]  be,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);

    logic full_write;
    assign full_write = wr_hit && (be == '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (full_write) begin
            q <= wdata & ADDR_KEEP_MASK;
        end
    end

    AST_ADDR_LATCH: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && be == 4'hF) |=> (q == ($past(wdata) & 32'h8FFF_FFFC))); // R1

    AST_PARTIAL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && be != 4'hF) |=> $stable(q)); // R2

endmodule

// File: rtl/cfg_xact_fsm.sv
module cfg_xact_fsm
    import cfg_port_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              start_write,
    input  cfg_target_t       tgt_in,
    input  logic [LANES-1:0]  be_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic              rsp_ack,
    input  logic [DATA_W-1:0] rsp_rdata,
    output logic              idle,
    output logic              busy,
    output logic              done,
    output logic              req_write,
    output cfg_target_t       req_tgt,
    output logic [LANES-1:0]  req_be,
    output logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);

    xact_state_e   state_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            rdata     <= '0;
            req_write <= 1'b0;
            req_tgt   <= '0;
            req_be    <= '0;
            req_wdata <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q   <= ST_BUSY;
                        cnt_q     <= '0;
                        req_write <= start_write;
                        req_tgt   <= tgt_in;
                        req_be    <= be_in;
                        req_wdata <= wdata_in;
                    end
                end
                ST_BUSY: begin
                    if (rsp_ack) begin
                        rdata   <= req_write ? '1 : rsp_rdata;
                        state_q <= ST_DONE;
                    end else if (cnt_q == LAST) begin
                        rdata   <= '1;
                        state_q <= ST_DONE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign idle = (state_q == ST_IDLE);
    assign busy = (state_q == ST_BUSY);
    assign done = (state_q == ST_DONE);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && !rsp_ack && cnt_q != LAST) |=>
            (busy && $stable(req_tgt) && $stable(req_be) && $stable(req_wdata) && $stable(req_write))); // R6

    AST_ACK_DATA: assert property (@(posedge clk) disable iff (rst)
        (busy && rsp_ack && !req_write) |=> (done && rdata == $past(rsp_rdata))); // R4

    AST_TIMEOUT_ONES: assert property (@(posedge clk) disable iff (rst)
        (busy && !rsp_ack && cnt_q == LAST) |=> (done && rdata == 32'hFFFF_FFFF)); // R7

endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder
    import cfg_port_pkg::*;
#(
    parameter logic [15:0] ADDR_PORT      = 16'h0CF8,
    parameter logic [15:0] DATA_PORT      = 16'h0CFC,
    parameter int          TIMEOUT_CYCLES = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] io_port,
    input  logic [3:0]  io_be,
    input  logic        io_rd,
    input  logic        io_wr,
    input  logic [31:0] io_wdata,
    output logic [31:0] io_rdata,
    output logic        io_ready,
    output logic        req_valid,
    output logic        req_write,
    output logic [7:0]  req_bus,
    output logic [7:0]  req_devfn,
    output logic [9:0]  req_dw_idx,
    output logic [3:0]  req_be,
    output logic [31:0] req_wdata,
    input  logic        rsp_ack,
    input  logic [31:0] rsp_rdata
);

    acc_kind_e         kind;
    logic [DATA_W-1:0] addr_q;
    logic              win_en;
    logic              fsm_idle;
    logic              fsm_done;
    logic              start;
    logic              addr_wr_hit;
    logic              quick_done;
    cfg_target_t       req_tgt;
    logic [DATA_W-1:0] fsm_rdata;

    cfg_port_decode #(
        .ADDR_PORT (ADDR_PORT),
        .DATA_PORT (DATA_PORT)
    ) decode_i (
        .io_port (io_port),
        .io_be   (io_be),
        .io_rd   (io_rd),
        .io_wr   (io_wr),
        .kind    (kind)
    );

    assign addr_wr_hit = fsm_idle && io_wr && (kind == ACC_ADDR);

    cfg_addr_reg addr_i (
        .clk    (clk),
        .rst    (rst),
        .wr_hit (addr_wr_hit),
        .be     (io_be),
        .wdata  (io_wdata),
        .q      (addr_q)
    );

    assign win_en = addr_q[31];
    assign start  = fsm_idle && win_en && (kind == ACC_WIN);

    cfg_xact_fsm #(
        .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
    ) fsm_i (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .start_write (io_wr),
        .tgt_in      (target_of(addr_q)),
        .be_in       (io_be),
        .wdata_in    (io_wdata),
        .rsp_ack     (rsp_ack),
        .rsp_rdata   (rsp_rdata),
        .idle        (fsm_idle),
        .busy        (req_valid),
        .done        (fsm_done),
        .req_write   (req_write),
        .req_tgt     (req_tgt),
        .req_be      (req_be),
        .req_wdata   (req_wdata),
        .rdata       (fsm_rdata)
    );

    assign req_bus    = req_tgt.bus;
    assign req_devfn  = req_tgt.devfn;
    assign req_dw_idx = req_tgt.dw_idx;

    always_comb begin
        quick_done = fsm_idle && ((kind == ACC_ADDR) || (kind == ACC_OTHER) ||
                                  ((kind == ACC_WIN) && !win_en));
        io_ready   = fsm_done || quick_done;
        if (fsm_done) begin
            io_rdata = fsm_rdata;
        end else if (kind == ACC_ADDR) begin
            io_rdata = addr_q;
        end else begin
            io_rdata = '1;
        end
    end

    AST_STALL_WHILE_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> !io_ready); // R6

    AST_DISABLED_ONES: assert property (@(posedge clk) disable iff (rst)
        (fsm_idle && kind == ACC_WIN && !addr_q[31] && io_rd && !io_wr) |->
            (io_ready && io_rdata == 32'hFFFF_FFFF)); // R5

    AST_NO_REQ_DISABLED: assert property (@(posedge clk) disable iff (rst)
        $rose(req_valid) |-> $past(addr_q[31])); // R5

endmodule

// File: tb/cfg_port_decoder_tb_top.sv
module cfg_port_decoder_tb_top;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int TMO = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_port = '0;
    logic [3:0]  io_be = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [31:0] io_wdata = '0;
    logic [31:0] io_rdata;
    logic        io_ready;
    logic        req_valid, req_write;
    logic [7:0]  req_bus, req_devfn;
    logic [9:0]  req_dw_idx;
    logic [3:0]  req_be;
    logic [31:0] req_wdata;
    logic        rsp_ack = 1'b0;
    logic [31:0] rsp_rdata = '0;

    always #2.5 clk = ~clk;

    cfg_port_decoder #(.TIMEOUT_CYCLES(TMO)) dut_i (
        .clk(clk), .rst(rst), .io_port(io_port), .io_be(io_be), .io_rd(io_rd),
        .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata), .io_ready(io_ready),
        .req_valid(req_valid), .req_write(req_write), .req_bus(req_bus),
        .req_devfn(req_devfn), .req_dw_idx(req_dw_idx), .req_be(req_be),
        .req_wdata(req_wdata), .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata)
    );

    int total = 0;
    int bad = 0;

    function automatic logic [31:0] mdl(input logic [7:0] b, input logic [7:0] d, input logic [9:0] x);
        return {b ^ 8'h5A, d, x[5:0], x[9:6], 6'h2A};
    endfunction

    function automatic logic [31:0] lane_mask(input logic [3:0] be);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
        return m;
    endfunction

    function automatic logic [1:0] low_lane(input logic [3:0] be);
        logic [1:0] r;
        r = 2'd0;
        for (int i = 3; i >= 0; i--) if (be[i]) r = 2'(i);
        return r;
    endfunction

    // back-end target model
    int          be_delay = 0;
    int          bwait = 0;
    int          req_cyc = 0;
    int          req_starts = 0;
    logic        prev_rv = 1'b0;
    logic        lg_write;
    logic [7:0]  lg_bus, lg_devfn;
    logic [9:0]  lg_idx;
    logic [3:0]  lg_be;
    logic [31:0] lg_wdata;

    always @(negedge clk) begin
        if (req_valid) begin
            if (!prev_rv) req_starts++;
            req_cyc++;
            if (be_delay >= 0 && bwait == be_delay) begin
                rsp_ack   = 1'b1;
                rsp_rdata = mdl(req_bus, req_devfn, req_dw_idx);
                lg_write  = req_write;
                lg_bus    = req_bus;
                lg_devfn  = req_devfn;
                lg_idx    = req_dw_idx;
                lg_be     = req_be;
                lg_wdata  = req_wdata;
            end else begin
                rsp_ack = 1'b0;
            end
            bwait++;
        end else begin
            rsp_ack = 1'b0;
            bwait   = 0;
        end
        prev_rv = req_valid;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic io_acc(input logic wr, input logic [15:0] port, input logic [3:0] be,
                          input logic [31:0] wd, output logic [31:0] rd, output int waits);
        @(negedge clk);
        io_port = port; io_be = be; io_wdata = wd; io_wr = wr; io_rd = !wr;
        waits = 0;
        #1;
        while (!io_ready) begin
            @(negedge clk);
            #1;
            waits++;
        end
        rd = io_rdata;
        @(negedge clk);
        io_rd = 1'b0; io_wr = 1'b0;
    endtask

    task automatic set_addr(input logic [31:0] v);
        logic [31:0] rd;
        int w;
        io_acc(1'b1, 16'h0CF8, 4'hF, v, rd, w);
    endtask

    task automatic get_addr(output logic [31:0] v);
        int w;
        io_acc(1'b0, 16'h0CF8, 4'hF, 32'h0, v, w);
    endtask

    initial begin
        #(150000 * 5);
        total++;
        bad++;
        $display("FAIL watchdog expired act=%h exp=%h", 32'h0, 32'h1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rd, v, base, a;
        int w, s0, c0;

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(req_valid == 1'b0, "R9 req_valid after reset", {31'b0, req_valid}, 32'h0);
        chk(io_ready == 1'b0, "R9 io_ready idle", {31'b0, io_ready}, 32'h0);
        get_addr(rd);
        chk(rd == 32'h0, "R9 address register reset value", rd, 32'h0);

        // R1: walking ones and all ones
        for (int b = 0; b < 32; b++) begin
            v = 32'h1 << b;
            set_addr(v);
            get_addr(rd);
            chk(rd == (v & 32'h8FFF_FFFC), "R1 walking bit readback", rd, v & 32'h8FFF_FFFC);
        end
        set_addr(32'hFFFF_FFFF);
        get_addr(rd);
        chk(rd == 32'h8FFF_FFFC, "R1 all ones readback", rd, 32'h8FFF_FFFC);

        // R2: every non-full byte-enable pattern on the address dword
        base = 32'h8A5A_3C04;
        set_addr(base);
        for (int e = 1; e < 15; e++) begin
            io_acc(1'b1, 16'h0CF8 + 16'(low_lane(4'(e))), 4'(e), ~base, rd, w);
            get_addr(rd);
            chk(rd == base, "R2 partial write ignored", rd, base);
        end
        io_acc(1'b1, 16'h0CFB, 4'b1000, 32'h0100_0000, rd, w);
        get_addr(rd);
        chk(rd == base, "R2 byte write to 0xCFB ignored", rd, base);

        // R8: foreign ports and malformed lanes
        s0 = req_starts;
        io_acc(1'b0, 16'h0080, 4'hF, 32'h0, rd, w);
        chk(rd == 32'hFFFF_FFFF && w == 0, "R8 foreign read", rd, 32'hFFFF_FFFF);
        io_acc(1'b1, 16'h0CF4, 4'hF, 32'h0, rd, w);
        chk(w == 0, "R8 foreign write ready", 32'(w), 32'h0);
        io_acc(1'b0, 16'h0CFC, 4'b0010, 32'h0, rd, w);
        chk(rd == 32'hFFFF_FFFF && w == 0, "R8 malformed window read", rd, 32'hFFFF_FFFF);
        io_acc(1'b1, 16'h0CF9, 4'hF, 32'h0, rd, w);
        get_addr(rd);
        chk(rd == base, "R8 malformed address write ignored", rd, base);
        chk(req_starts == s0, "R8 no request issued", 32'(req_starts), 32'(s0));

        // R5: enable clear
        set_addr(32'h0A5A_3C04);
        s0 = req_starts;
        for (int n = 0; n < 4; n++) begin
            io_acc(1'b0, 16'h0CFC + 16'(n), 4'(1 << n), 32'h0, rd, w);
            chk(rd == 32'hFFFF_FFFF && w == 0, "R5 disabled window read", rd, 32'hFFFF_FFFF);
        end
        io_acc(1'b1, 16'h0CFC, 4'hF, 32'h1234_5678, rd, w);
        chk(w == 0, "R5 disabled window write ready", 32'(w), 32'h0);
        chk(req_starts == s0, "R5 no request while disabled", 32'(req_starts), 32'(s0));

        // R3 / R4: field packing sweep with dword reads
        be_delay = 0;
        for (int i = 0; i < 64; i++) begin
            logic [7:0]  bb, dd;
            logic [11:0] off;
            logic [9:0]  ix;
            bb  = 8'(i * 4 + 1);
            dd  = 8'(255 - i * 3);
            off = 12'(i * 64 + (i % 16) * 4);
            ix  = off[11:2];
            a   = {1'b1, 3'b000, off[11:8], bb, dd, off[7:2], 2'b00};
            set_addr(a);
            io_acc(1'b0, 16'h0CFC, 4'hF, 32'h0, rd, w);
            chk(lg_bus == bb && lg_devfn == dd, "R3 bus/devfn fields", {lg_bus, lg_devfn, 16'h0}, {bb, dd, 16'h0});
            chk(lg_idx == ix, "R3 dword index", 32'(lg_idx), 32'(ix));
            chk(rd == mdl(bb, dd, ix) && lg_write == 1'b0, "R4 dword read data", rd, mdl(bb, dd, ix));
        end

        // R4: byte and word lanes
        a = {1'b1, 3'b000, 4'h3, 8'h21, 8'h43, 6'h15, 2'b00};
        set_addr(a);
        for (int n = 0; n < 4; n++) begin
            logic [3:0] be;
            be = 4'(1 << n);
            io_acc(1'b0, 16'h0CFC + 16'(n), be, 32'h0, rd, w);
            chk(lg_be == be, "R4 byte read lanes", 32'(lg_be), 32'(be));
            chk((rd & lane_mask(be)) == (mdl(8'h21, 8'h43, {4'h3, 6'h15}) & lane_mask(be)),
                "R4 byte read data", rd, mdl(8'h21, 8'h43, {4'h3, 6'h15}));
            v = 32'hC3 << (8 * n);
            io_acc(1'b1, 16'h0CFC + 16'(n), be, v, rd, w);
            chk(lg_write == 1'b1 && lg_be == be, "R4 byte write lanes", 32'(lg_be), 32'(be));
            chk((lg_wdata & lane_mask(be)) == v, "R4 byte write data", lg_wdata, v);
        end
        for (int h = 0; h < 2; h++) begin
            logic [3:0] be;
            be = 4'(3 << (2 * h));
            io_acc(1'b0, 16'h0CFC + 16'(2 * h), be, 32'h0, rd, w);
            chk(lg_be == be, "R4 word read lanes", 32'(lg_be), 32'(be));
            v = 32'hBEEF << (16 * h);
            io_acc(1'b1, 16'h0CFC + 16'(2 * h), be, v, rd, w);
            chk((lg_wdata & lane_mask(be)) == v && lg_be == be, "R4 word write data", lg_wdata, v);
        end

        // R6: acknowledge delay sweep
        for (int d = 0; d < 8; d++) begin
            be_delay = d;
            io_acc(1'b0, 16'h0CFC, 4'hF, 32'h0, rd, w);
            chk(w == d + 2, "R6 stall length", 32'(w), 32'(d + 2));
            chk(rd == mdl(8'h21, 8'h43, {4'h3, 6'h15}), "R6 data after stall", rd, mdl(8'h21, 8'h43, {4'h3, 6'h15}));
        end

        // R7: silent target
        be_delay = -1;
        c0 = req_cyc;
        io_acc(1'b0, 16'h0CFC, 4'hF, 32'h0, rd, w);
        chk(rd == 32'hFFFF_FFFF, "R7 timeout read data", rd, 32'hFFFF_FFFF);
        chk(w == TMO + 1, "R7 timeout stall length", 32'(w), 32'(TMO + 1));
        chk(req_cyc - c0 == TMO, "R7 request window", 32'(req_cyc - c0), 32'(TMO));
        io_acc(1'b1, 16'h0CFC, 4'hF, 32'h5555_AAAA, rd, w);
        chk(w == TMO + 1, "R7 timeout write completes", 32'(w), 32'(TMO + 1));
        be_delay = 1;
        io_acc(1'b0, 16'h0CFC, 4'hF, 32'h0, rd, w);
        chk(rd == mdl(8'h21, 8'h43, {4'h3, 6'h15}) && w == 3, "R7 recovery after timeout", rd, mdl(8'h21, 8'h43, {4'h3, 6'h15}));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule